// File: doc/BRIEF.md
# SPI Master I/O Timing Adjuster

This block sits between the serial shift engine of an SPI master and the pad ring. At high serial rates the round trip through pads and board traces eats a large part of a bit period. The block lets that be tuned in whole core-clock cycles. The outgoing data line can be held back by up to three core cycles. The incoming data line can be held back by up to three core cycles. The point at which a received bit is latched can be moved from two cycles ahead of the nominal sampling edge to one cycle after it.

The shift engine supplies an early strobe, `pre_stb`. A counter in the engine raises it exactly two core cycles before the nominal sampling edge. The block delays this strobe by the programmed capture code and returns it as `cap_stb`. On that strobe it latches the delayed incoming bit into `miso_bit`. In automatic mode, the receive-side settings come from the current core-to-SCLK division ratio and the programmed receive fields are ignored. Whatever the source of the receive settings, they are clamped so that the capture offset plus the input delay stays inside one bit period. All delay lines are cleared when a burst starts.

Top module: `spi_io_tuner`

## Requirements
- R1: `mosi_pin` equals `mosi_int` from `cfg_out_dly` core cycles earlier. A value of 0 is a same-cycle pass-through, and 1, 2 and 3 delay by that many cycles.
- R2: The bit latched on a capture strobe is the value `miso_pin` had the effective input delay (0 to 3) cycles before the strobe cycle.
- R3: The capture code selects the delay from `pre_stb` to `cap_stb`. Code 0 gives the same cycle (two cycles ahead of nominal), code 1 gives one cycle (one ahead), code 2 gives two cycles (nominal) and code 3 gives three cycles (one late).
- R4: `miso_bit` and `miso_bit_vld` are registered. They reflect a capture in the cycle after `cap_stb`. `miso_bit` holds its value in every cycle that follows a cycle without `cap_stb`.
- R5: With `cfg_auto`=1 and a division ratio above CORE_MHZ/40, the input delay is 3 for ratios of 16 or more, 2 for 8 to 15, 1 for 6 to 7, and 0 otherwise. For lower ratios it is 0.
- R6: With `cfg_auto`=1 the capture code is 3 when the ratio is at most CORE_MHZ/100, 2 when it is at most CORE_MHZ/80, 1 when it is at most CORE_MHZ/40, and 0 above that. `cfg_in_dly` and `cfg_cap_sel` have no effect in this mode.
- R7: With R = max(ratio-1, 0), the capture code is limited to R. The input delay is then limited to R minus the capture code, so that code plus delay never exceeds R.
- R8: In the cycle after `burst_start`, every delay tap reads 0. A delayed `mosi_pin` is then 0 until new data has propagated through the taps.
- R9: During reset all taps, `miso_bit` and `miso_bit_vld` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| burst_start | input | 1 | Clears all delay taps |
| cfg_auto | input | 1 | 1: receive settings derived from div_ratio |
| cfg_out_dly | input | 2 | Outgoing data delay in core cycles |
| cfg_in_dly | input | 2 | Incoming data delay in core cycles (manual mode) |
| cfg_cap_sel | input | 2 | Capture point code (manual mode) |
| div_ratio | input | DIV_W | Effective core cycles per SCLK period |
| mosi_int | input | 1 | Outgoing bit from the shift engine |
| pre_stb | input | 1 | Strobe two cycles before the nominal sampling edge |
| miso_pin | input | 1 | Raw incoming data line |
| mosi_pin | output | 1 | Delayed outgoing data line |
| cap_stb | output | 1 | Capture strobe returned to the shift engine |
| miso_bit | output | 1 | Last captured incoming bit |
| miso_bit_vld | output | 1 | Pulses the cycle after a capture |

## Verification
Some properties are checked by the assertions on every cycle. These are the same-cycle pass-through and the one-cycle delay of the outgoing line, and the zeroed outgoing line after a burst start. They also cover the hold of the captured bit between strobes, the one-period limit on capture code plus input delay, and the automatic settings at low rates. Other behaviour can only be shown by the bench. It pulses a lone strobe and a lone receive pulse at varying offsets, then measures from the ports the actual capture delay and the input delay that follow. This is how the full ratio-to-setting map, the clamping of out-of-range programs and the ignored manual fields in automatic mode are shown.

// File: rtl/spi_iotune_pkg.sv
package spi_iotune_pkg;

  localparam int unsigned TUNE_W    = 2;
  localparam int unsigned TAP_DEPTH = (1 << TUNE_W) - 1;

  // ratio breakpoints for the automatic input delay
  localparam int unsigned IN3_MIN_DIV = 16;
  localparam int unsigned IN2_MIN_DIV = 8;
  localparam int unsigned IN1_MIN_DIV = 6;

  // serial-rate breakpoints (MHz) for the automatic capture point
  localparam int unsigned LATE_MHZ    = 100;
  localparam int unsigned NOMINAL_MHZ = 80;
  localparam int unsigned AHEAD1_MHZ  = 40;

  // code equals the delay in cycles from pre_stb to the capture strobe
  typedef enum logic [TUNE_W-1:0] {
    CAP_AHEAD2  = 2'd0,
    CAP_AHEAD1  = 2'd1,
    CAP_NOMINAL = 2'd2,
    CAP_LATE1   = 2'd3
  } cap_pt_e;

  typedef struct packed {
    logic [TUNE_W-1:0] in_dly;
    cap_pt_e           cap;
  } rx_tune_t;

  // largest ratio that still reaches the given serial rate
  function automatic int unsigned rate_div_max(input int unsigned core_mhz,
                                               input int unsigned rate_mhz);
    return core_mhz / rate_mhz;
  endfunction

  function automatic rx_tune_t auto_tune(input int unsigned div,
                                         input int unsigned core_mhz);
    rx_tune_t t;
    t.in_dly = '0;
    t.cap    = CAP_AHEAD2;
    if (div <= rate_div_max(core_mhz, LATE_MHZ))         t.cap = CAP_LATE1;
    else if (div <= rate_div_max(core_mhz, NOMINAL_MHZ)) t.cap = CAP_NOMINAL;
    else if (div <= rate_div_max(core_mhz, AHEAD1_MHZ))  t.cap = CAP_AHEAD1;
    else if (div >= IN3_MIN_DIV)                         t.in_dly = 2'd3;
    else if (div >= IN2_MIN_DIV)                         t.in_dly = 2'd2;
    else if (div >= IN1_MIN_DIV)                         t.in_dly = 2'd1;
    return t;
  endfunction

  // keep capture offset plus input delay inside one bit period
  function automatic rx_tune_t clamp_tune(input rx_tune_t raw,
                                          input int unsigned div);
    int unsigned room;
    int unsigned cap_n;
    int unsigned in_n;
    rx_tune_t    t;
    room  = (div == 0) ? 0 : div - 1;
    cap_n = 32'(raw.cap);
    if (cap_n > room) cap_n = room;
    in_n = 32'(raw.in_dly);
    if (in_n > room - cap_n) in_n = room - cap_n;
    t.cap    = cap_pt_e'(cap_n[TUNE_W-1:0]);
    t.in_dly = in_n[TUNE_W-1:0];
    return t;
  endfunction

endpackage

// File: rtl/iotune_dly_line.sv
module iotune_dly_line #(
  parameter int unsigned DEPTH = 3,
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             d,
  input  logic [SEL_W-1:0] sel,
  output logic             q
);

  logic [DEPTH-1:0] tap;

  for (genvar i = 0; i < DEPTH; i++) begin : g_tap
    if (i == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     tap[i] <= 1'b0;
        else if (flush) tap[i] <= 1'b0;
        else            tap[i] <= d;
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     tap[i] <= 1'b0;
        else if (flush) tap[i] <= 1'b0;
        else            tap[i] <= tap[i-1];
      end
    end
  end

  always_comb begin
    q = d;
    for (int j = 1; j <= int'(DEPTH); j++) begin
      if (int'(sel) == j) q = tap[j-1];
    end
  end

endmodule

// File: rtl/iotune_rx_sel.sv
module iotune_rx_sel
  import spi_iotune_pkg::*;
#(
  parameter int unsigned DIV_W    = 8,
  parameter int unsigned CORE_MHZ = 250
) (
  input  logic              cfg_auto,
  input  logic [TUNE_W-1:0] cfg_in_dly,
  input  logic [TUNE_W-1:0] cfg_cap_sel,
  input  logic [DIV_W-1:0]  div_ratio,
  output rx_tune_t          rx_eff
);

  rx_tune_t manual_tune;
  rx_tune_t raw_tune;

  always_comb begin
    manual_tune.in_dly = cfg_in_dly;
    manual_tune.cap    = cap_pt_e'(cfg_cap_sel);
    raw_tune = cfg_auto ? auto_tune(32'(div_ratio), CORE_MHZ) : manual_tune;
    rx_eff   = clamp_tune(raw_tune, 32'(div_ratio));
  end

endmodule

// File: rtl/spi_io_tuner.sv
module spi_io_tuner
  import spi_iotune_pkg::*;
#(
  parameter int unsigned DIV_W    = 8,
  parameter int unsigned CORE_MHZ = 250
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              burst_start,
  input  logic              cfg_auto,
  input  logic [TUNE_W-1:0] cfg_out_dly,
  input  logic [TUNE_W-1:0] cfg_in_dly,
  input  logic [TUNE_W-1:0] cfg_cap_sel,
  input  logic [DIV_W-1:0]  div_ratio,
  input  logic              mosi_int,
  input  logic              pre_stb,
  input  logic              miso_pin,
  output logic              mosi_pin,
  output logic              cap_stb,
  output logic              miso_bit,
  output logic              miso_bit_vld
);

  rx_tune_t          rx_eff;
  logic [TUNE_W-1:0] in_dly_eff;
  logic [TUNE_W-1:0] cap_eff;
  logic              miso_dly;

  iotune_rx_sel #(.DIV_W(DIV_W), .CORE_MHZ(CORE_MHZ)) sel_i (
    .cfg_auto    (cfg_auto),
    .cfg_in_dly  (cfg_in_dly),
    .cfg_cap_sel (cfg_cap_sel),
    .div_ratio   (div_ratio),
    .rx_eff      (rx_eff)
  );

  assign in_dly_eff = rx_eff.in_dly;
  assign cap_eff    = rx_eff.cap;

  iotune_dly_line #(.DEPTH(TAP_DEPTH), .SEL_W(TUNE_W)) tx_line_i (
    .clk (clk), .rst_n (rst_n), .flush (burst_start),
    .d (mosi_int), .sel (cfg_out_dly), .q (mosi_pin)
  );

  iotune_dly_line #(.DEPTH(TAP_DEPTH), .SEL_W(TUNE_W)) rx_line_i (
    .clk (clk), .rst_n (rst_n), .flush (burst_start),
    .d (miso_pin), .sel (in_dly_eff), .q (miso_dly)
  );

  iotune_dly_line #(.DEPTH(TAP_DEPTH), .SEL_W(TUNE_W)) stb_line_i (
    .clk (clk), .rst_n (rst_n), .flush (burst_start),
    .d (pre_stb), .sel (cap_eff), .q (cap_stb)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      miso_bit     <= 1'b0;
      miso_bit_vld <= 1'b0;
    end else begin
      miso_bit_vld <= cap_stb;
      if (cap_stb) miso_bit <= miso_dly;
    end
  end

endmodule

// File: rtl/spi_io_tuner_chk.sv
module spi_io_tuner_chk #(
  parameter int unsigned DIV_W    = 8,
  parameter int unsigned CORE_MHZ = 250
) (
  input logic             clk,
  input logic             rst_n,
  input logic             burst_start,
  input logic             cfg_auto,
  input logic [1:0]       cfg_out_dly,
  input logic [DIV_W-1:0] div_ratio,
  input logic             mosi_int,
  input logic             mosi_pin,
  input logic             pre_stb,
  input logic             cap_stb,
  input logic             miso_bit,
  input logic [1:0]       in_dly_eff,
  input logic [1:0]       cap_eff
);

  localparam int unsigned SLOW_DIV = CORE_MHZ / 40;

  logic seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  // R1
  out_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_out_dly == 2'd0) |-> (mosi_pin == mosi_int));

  // R1
  out_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && cfg_out_dly == 2'd1 && $past(cfg_out_dly) == 2'd1 && !$past(burst_start))
      |-> (mosi_pin == $past(mosi_int)));

  // R8
  flush_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(burst_start) && cfg_out_dly != 2'd0) |-> !mosi_pin);

  // R3
  cap_ahead2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_eff == 2'd0) |-> (cap_stb == pre_stb));

  // R4
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_stb |=> $stable(miso_bit));

  // R7
  window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(cap_eff) + 32'(in_dly_eff) + ((div_ratio == '0) ? 32'd1 : 32'd0)) <= 32'(div_ratio)
      || (div_ratio == '0 && cap_eff == 2'd0 && in_dly_eff == 2'd0));

  // R5
  auto_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_auto && 32'(div_ratio) > SLOW_DIV && 32'(div_ratio) >= 32'd16)
      |-> (in_dly_eff == 2'd3));

  // R6
  auto_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_auto && 32'(div_ratio) > SLOW_DIV) |-> (cap_eff == 2'd0));

endmodule

bind spi_io_tuner spi_io_tuner_chk #(.DIV_W(DIV_W), .CORE_MHZ(CORE_MHZ)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .burst_start (burst_start),
  .cfg_auto    (cfg_auto),
  .cfg_out_dly (cfg_out_dly),
  .div_ratio   (div_ratio),
  .mosi_int    (mosi_int),
  .mosi_pin    (mosi_pin),
  .pre_stb     (pre_stb),
  .cap_stb     (cap_stb),
  .miso_bit    (miso_bit),
  .in_dly_eff  (in_dly_eff),
  .cap_eff     (cap_eff)
);

// File: tb/spi_io_tuner_tb_top.sv
module spi_io_tuner_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       burst_start = 1'b0;
  logic       cfg_auto = 1'b0;
  logic [1:0] cfg_out_dly = 2'd0;
  logic [1:0] cfg_in_dly = 2'd0;
  logic [1:0] cfg_cap_sel = 2'd0;
  logic [7:0] div_ratio = 8'd20;
  logic       mosi_int = 1'b0;
  logic       pre_stb = 1'b0;
  logic       miso_pin = 1'b0;
  logic       mosi_pin, cap_stb, miso_bit, miso_bit_vld;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  spi_io_tuner #(.DIV_W(8), .CORE_MHZ(250)) dut_i (
    .clk (clk), .rst_n (rst_n), .burst_start (burst_start),
    .cfg_auto (cfg_auto), .cfg_out_dly (cfg_out_dly), .cfg_in_dly (cfg_in_dly),
    .cfg_cap_sel (cfg_cap_sel), .div_ratio (div_ratio), .mosi_int (mosi_int),
    .pre_stb (pre_stb), .miso_pin (miso_pin), .mosi_pin (mosi_pin),
    .cap_stb (cap_stb), .miso_bit (miso_bit), .miso_bit_vld (miso_bit_vld)
  );

  typedef struct packed {
    logic       auto_m;
    logic [7:0] div;
    logic [1:0] in_c;
    logic [1:0] cap_c;
    logic [1:0] exp_in;
    logic [1:0] exp_cap;
    logic [1:0] tag;   // 0 manual, 1 automatic, 2 clamp
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 8'd20,  2'd0, 2'd2, 2'd0, 2'd2, 2'd0},
    '{1'b0, 8'd20,  2'd3, 2'd3, 2'd3, 2'd3, 2'd0},
    '{1'b0, 8'd20,  2'd2, 2'd1, 2'd2, 2'd1, 2'd0},
    '{1'b0, 8'd20,  2'd1, 2'd0, 2'd1, 2'd0, 2'd0},
    '{1'b1, 8'd2,   2'd0, 2'd0, 2'd0, 2'd1, 2'd2},
    '{1'b1, 8'd3,   2'd0, 2'd0, 2'd0, 2'd2, 2'd1},
    '{1'b1, 8'd4,   2'd0, 2'd0, 2'd0, 2'd1, 2'd1},
    '{1'b1, 8'd6,   2'd0, 2'd0, 2'd0, 2'd1, 2'd1},
    '{1'b1, 8'd7,   2'd0, 2'd0, 2'd1, 2'd0, 2'd1},
    '{1'b1, 8'd8,   2'd0, 2'd0, 2'd2, 2'd0, 2'd1},
    '{1'b1, 8'd15,  2'd0, 2'd0, 2'd2, 2'd0, 2'd1},
    '{1'b1, 8'd16,  2'd0, 2'd0, 2'd3, 2'd0, 2'd1},
    '{1'b1, 8'd200, 2'd1, 2'd3, 2'd3, 2'd0, 2'd1},
    '{1'b0, 8'd4,   2'd3, 2'd3, 2'd0, 2'd3, 2'd2},
    '{1'b0, 8'd5,   2'd3, 2'd2, 2'd2, 2'd2, 2'd2},
    '{1'b0, 8'd1,   2'd2, 2'd2, 2'd0, 2'd0, 2'd2}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic flush_cycle();
    @(negedge clk);
    burst_start = 1'b1; pre_stb = 1'b0; miso_pin = 1'b0; mosi_int = 1'b0;
    @(negedge clk);
    burst_start = 1'b0;
  endtask

  // one lone strobe at c=0 and one lone receive pulse at c=k
  task automatic probe(input int k, output int cap_m, output bit hit);
    flush_cycle();
    repeat (4) @(negedge clk);
    cap_m = -1;
    hit = 1'b0;
    for (int c = -4; c <= 6; c++) begin
      pre_stb  = (c == 0);
      miso_pin = (c == k);
      #1;
      if (cap_stb && cap_m < 0) cap_m = c;
      @(negedge clk);
      if (miso_bit_vld && miso_bit) hit = 1'b1;
    end
    pre_stb = 1'b0;
    miso_pin = 1'b0;
  endtask

  task automatic measure(output int cap_m, output int in_m);
    int  c_tmp;
    bit  h;
    in_m = 99;
    cap_m = -1;
    for (int k = -3; k <= 3; k++) begin
      probe(k, c_tmp, h);
      cap_m = c_tmp;
      if (h) in_m = c_tmp - k;
    end
  endtask

  function automatic string cap_req(input logic [1:0] tag);
    case (tag)
      2'd1:    return "R6";
      2'd2:    return "R7";
      default: return "R3";
    endcase
  endfunction

  function automatic string in_req(input logic [1:0] tag);
    case (tag)
      2'd1:    return "R5";
      2'd2:    return "R7";
      default: return "R2";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      summary();
      $finish;
    end
  end

  initial begin
    int cap_m, in_m;
    bit ok;
    logic [11:0] pat;

    // R9: reset state
    cfg_out_dly = 2'd1; cfg_cap_sel = 2'd2; mosi_int = 1'b1; pre_stb = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(mosi_pin == 1'b0, "R9", "mosi_pin in reset", mosi_pin, 0);
    chk(cap_stb == 1'b0, "R9", "cap_stb in reset", cap_stb, 0);
    chk(miso_bit == 1'b0 && miso_bit_vld == 1'b0, "R9", "miso outputs in reset",
        {miso_bit, miso_bit_vld}, 0);
    pre_stb = 1'b0; mosi_int = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Table: receive delay and capture point measured at the ports
    for (int v = 0; v < NVEC; v++) begin
      cfg_auto    = VEC[v].auto_m;
      div_ratio   = VEC[v].div;
      cfg_in_dly  = VEC[v].in_c;
      cfg_cap_sel = VEC[v].cap_c;
      measure(cap_m, in_m);
      chk(cap_m == int'(VEC[v].exp_cap), cap_req(VEC[v].tag), $sformatf("capture delay vec %0d", v),
          cap_m, int'(VEC[v].exp_cap));
      chk(in_m == int'(VEC[v].exp_in), in_req(VEC[v].tag), $sformatf("input delay vec %0d", v),
          in_m, int'(VEC[v].exp_in));
    end

    // R1: outgoing delay for each code
    cfg_auto = 1'b0; div_ratio = 8'd20;
    pat = 12'b1011_0011_1010;
    for (int d = 0; d < 4; d++) begin
      cfg_out_dly = 2'(d);
      flush_cycle();
      ok = 1'b1;
      for (int c = 0; c < 12; c++) begin
        mosi_int = pat[c];
        #1;
        if (mosi_pin !== ((c >= d) ? pat[c-d] : 1'b0)) ok = 1'b0;
        @(negedge clk);
      end
      chk(ok, "R1", $sformatf("mosi_pin trace for delay %0d", d), ok, 1);
    end

    // R8: burst start clears taps of a full line
    cfg_out_dly = 2'd3;
    mosi_int = 1'b1;
    repeat (5) @(negedge clk);
    burst_start = 1'b1;
    @(negedge clk);
    burst_start = 1'b0;
    ok = 1'b1;
    for (int c = 1; c <= 3; c++) begin
      #1;
      if (mosi_pin !== 1'b0) ok = 1'b0;
      @(negedge clk);
    end
    chk(ok, "R8", "mosi_pin zero for three cycles after burst start", ok, 1);
    #1;
    chk(mosi_pin == 1'b1, "R8", "mosi_pin after refill", mosi_pin, 1);
    mosi_int = 1'b0;

    // R4: capture registers and hold between strobes
    cfg_in_dly = 2'd0; cfg_cap_sel = 2'd0;
    flush_cycle();
    pre_stb = 1'b1; miso_pin = 1'b1;
    @(negedge clk);
    pre_stb = 1'b0; miso_pin = 1'b0;
    chk(miso_bit == 1'b1 && miso_bit_vld == 1'b1, "R4", "capture one cycle after strobe",
        {miso_bit, miso_bit_vld}, 3);
    ok = 1'b1;
    for (int c = 0; c < 6; c++) begin
      miso_pin = ~miso_pin;
      @(negedge clk);
      if (miso_bit !== 1'b1 || miso_bit_vld !== 1'b0) ok = 1'b0;
    end
    chk(ok, "R4", "miso_bit held without strobe", ok, 1);
    pre_stb = 1'b1; miso_pin = 1'b0;
    @(negedge clk);
    pre_stb = 1'b0;
    chk(miso_bit == 1'b0 && miso_bit_vld == 1'b1, "R4", "second capture of zero",
        {miso_bit, miso_bit_vld}, 1);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule